// File: doc/BRIEF.md
# Masked Alarm Compare and Interrupt Flag Unit

This block sits next to a real-time clock's timekeeping counters. It compares the current BCD date, hours, minutes and seconds against four alarm registers. Each alarm register has a mask bit that takes its field out of the compare. The compare is evaluated only on a seconds-tick strobe. Alarm hits, watchdog expiry, power-fail events and an oscillator-failure indication are collected in an 8-bit flags register. Reading that register clears the event flags, except the oscillator-failure flag, which stays set until software writes it to zero.

An interrupt control register enables each event source onto the interrupt pin. It also picks the active polarity, and picks whether the pin pulses for a fixed number of clocks or holds a level until the flags are read. A calibration bit in the flags register replaces the normal interrupt behaviour with a square wave, derived from the block clock, on both the interrupt pin and a dedicated calibration output. Software reaches all of this through a small read/write register port with combinational read data.

Top module: `alarm_irq_unit`

## Requirements
- R1: After reset every register reads 0x00, `irq_o` is 1 (inactive, active-low by default) and `cal_o` is 0.
- R2: In each alarm register, bit 7 is a mask and bits 6:0 hold the BCD value. On a seconds tick, the alarm flag (flags bit 6) is set if every field whose mask is 0 equals the matching time input. A register with mask 1 never prevents the match.
- R3: Without a seconds tick the alarm flag is not set, even while the time equals the alarm.
- R4: A flags read (address 0) clears the watchdog (bit 7), alarm (bit 6) and power-fail (bit 5) flags after that cycle. An event that arrives in the same cycle as the read leaves its flag set.
- R5: `osc_fail_i` sets flags bit 4. A flags read does not clear it. A write with bit 4 = 0 clears it, and a write with bit 4 = 1 leaves it unchanged.
- R6: Flags bits 7:5 ignore writes, and bit 3 always reads 0.
- R7: When interrupt control bit 2 is 1 (level mode), the interrupt is asserted while any flag is set whose enable is set. The pairs are bit 7 with the watchdog flag, bit 6 with the alarm flag and bit 5 with the power-fail flag. The interrupt therefore holds until a flags read.
- R8: When interrupt control bit 2 is 0 (pulse mode), an enabled event asserts the interrupt for PULSE_LEN cycles, starting in the cycle after the event.
- R9: Interrupt control bit 3 picks the polarity: 1 drives `irq_o` high when asserted, 0 drives it low when asserted.
- R10: With flags bit 2 (calibration) set, `irq_o` and `cal_o` both carry a square wave that starts low and toggles every CAL_HALF clocks. The first rise comes CAL_HALF clocks after the write. With the bit clear, `cal_o` is 0.
- R11: The register map is: 0 flags, 1 interrupt control, 2 alarm seconds, 3 alarm minutes, 4 alarm hours, 5 alarm date. Addresses 6 and 7 read 0. Interrupt control bits 4, 1 and 0 read 0. Flags bits 1:0 are plain read/write bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Seconds tick strobe, one cycle |
| sec_i | input | 7 | Current seconds, BCD |
| min_i | input | 7 | Current minutes, BCD |
| hour_i | input | 7 | Current hours, BCD |
| date_i | input | 7 | Current date, BCD |
| pfail_ev_i | input | 1 | Power-fail event pulse |
| wdog_ev_i | input | 1 | Watchdog expiry pulse |
| osc_fail_i | input | 1 | Oscillator-failure indication |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, combinational |
| irq_o | output | 1 | Interrupt pin |
| cal_o | output | 1 | Calibration square wave |

## Verification
The assertions check on every cycle that the oscillator flag survives anything except a clearing write. They also check that an event always leaves its flag set even during a read, that an undisturbed read empties the event flags, that the alarm flag only rises after a tick, and that an enabled event starts the pulse counter. The exact masked-compare outcomes, the pulse width, the polarity and the wave phase can only be shown by the bench's scenarios. The same holds for the way reads and writes reach the flags at the ports.

// File: rtl/alarm_irq_pkg.sv
package alarm_irq_pkg;
  localparam int unsigned ADDR_W  = 3;
  localparam int unsigned NFIELD  = 4;
  localparam int unsigned FIELD_W = 7;

  localparam logic [ADDR_W-1:0] A_FLAGS = 3'd0;
  localparam logic [ADDR_W-1:0] A_ICTL  = 3'd1;
  localparam logic [ADDR_W-1:0] A_ASEC  = 3'd2;
  localparam logic [ADDR_W-1:0] A_AMIN  = 3'd3;
  localparam logic [ADDR_W-1:0] A_AHR   = 3'd4;
  localparam logic [ADDR_W-1:0] A_ADATE = 3'd5;

  // flags bit positions
  localparam int unsigned FL_WDOG  = 7;
  localparam int unsigned FL_ALARM = 6;
  localparam int unsigned FL_PFAIL = 5;
  localparam int unsigned FL_OSC   = 4;
  localparam int unsigned FL_CAL   = 2;
  localparam int unsigned FL_WEN   = 1;
  localparam int unsigned FL_REN   = 0;

  // interrupt control bit positions
  localparam int unsigned IC_WIE = 7;
  localparam int unsigned IC_AIE = 6;
  localparam int unsigned IC_PFE = 5;
  localparam int unsigned IC_POL = 3;
  localparam int unsigned IC_LVL = 2;
  localparam logic [7:0]  IC_MASK = 8'hEC;
endpackage

// File: rtl/alarm_match.sv
module alarm_match #(
  parameter int unsigned NF = 4,
  parameter int unsigned FW = 7
) (
  input  logic [NF-1:0][7:0]    alarm_i,
  input  logic [NF-1:0][FW-1:0] now_i,
  input  logic                  tick_i,
  output logic                  hit_o
);
  logic [NF-1:0] field_ok;

  for (genvar g = 0; g < NF; g++) begin : g_field
    assign field_ok[g] = alarm_i[g][7] | (alarm_i[g][FW-1:0] == now_i[g]);
  end

  assign hit_o = tick_i & (&field_ok);
endmodule

// File: rtl/flag_reg.sv
module flag_reg
  import alarm_irq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wdog_ev_i,
  input  logic       alarm_ev_i,
  input  logic       pfail_ev_i,
  input  logic       osc_ev_i,
  input  logic       rd_i,
  input  logic       wr_i,
  input  logic [3:0] wdata_i,   // {osc, cal, wen, ren}
  output logic [7:0] flags_o
);
  logic wdog_q, alarm_q, pfail_q, osc_q, cal_q, wen_q, ren_q;
  logic osc_clr;

  assign osc_clr = wr_i & ~wdata_i[3];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wdog_q  <= 1'b0;
      alarm_q <= 1'b0;
      pfail_q <= 1'b0;
      osc_q   <= 1'b0;
      cal_q   <= 1'b0;
      wen_q   <= 1'b0;
      ren_q   <= 1'b0;
    end else begin
      // new event wins over read clear
      wdog_q  <= wdog_ev_i  | (wdog_q  & ~rd_i);
      alarm_q <= alarm_ev_i | (alarm_q & ~rd_i);
      pfail_q <= pfail_ev_i | (pfail_q & ~rd_i);
      osc_q   <= osc_ev_i   | (osc_q   & ~osc_clr);
      if (wr_i) begin
        cal_q <= wdata_i[2];
        wen_q <= wdata_i[1];
        ren_q <= wdata_i[0];
      end
    end
  end

  always_comb begin
    flags_o           = '0;
    flags_o[FL_WDOG]  = wdog_q;
    flags_o[FL_ALARM] = alarm_q;
    flags_o[FL_PFAIL] = pfail_q;
    flags_o[FL_OSC]   = osc_q;
    flags_o[FL_CAL]   = cal_q;
    flags_o[FL_WEN]   = wen_q;
    flags_o[FL_REN]   = ren_q;
  end

  // R5
  osc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (osc_q && !osc_clr) |=> osc_q);
  // R4
  ev_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pfail_ev_i || wdog_ev_i) |=> (pfail_q || wdog_q));
  // R4
  rd_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !pfail_ev_i && !wdog_ev_i && !alarm_ev_i) |=> !(pfail_q || wdog_q || alarm_q));
endmodule

// File: rtl/irq_drive.sv
module irq_drive #(
  parameter int unsigned PULSE_LEN = 4,
  parameter int unsigned CAL_HALF  = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic trig_i,
  input  logic level_i,
  input  logic pol_i,
  input  logic cal_en_i,
  output logic irq_o,
  output logic cal_o
);
  localparam int unsigned PW = $clog2(PULSE_LEN + 1);
  localparam int unsigned CW = $clog2(CAL_HALF);

  logic [PW-1:0] pulse_cnt;
  logic [CW-1:0] cal_cnt;
  logic          wave_q;
  logic          asserted;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                pulse_cnt <= '0;
    else if (trig_i)            pulse_cnt <= PW'(PULSE_LEN);
    else if (pulse_cnt != '0)   pulse_cnt <= pulse_cnt - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cal_cnt <= '0;
      wave_q  <= 1'b0;
    end else if (!cal_en_i) begin
      cal_cnt <= '0;
      wave_q  <= 1'b0;
    end else if (cal_cnt == CW'(CAL_HALF - 1)) begin
      cal_cnt <= '0;
      wave_q  <= ~wave_q;
    end else begin
      cal_cnt <= cal_cnt + 1'b1;
    end
  end

  assign asserted = level_i ? active_i : (pulse_cnt != '0);
  assign cal_o    = wave_q & cal_en_i;
  assign irq_o    = cal_en_i ? wave_q : ~(asserted ^ pol_i);

  // R8
  pulse_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i |=> (pulse_cnt != '0));
  // R10
  wave_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wave_q) |-> $past(cal_en_i));
endmodule

// File: rtl/alarm_irq_unit.sv
module alarm_irq_unit
  import alarm_irq_pkg::*;
#(
  parameter int unsigned PULSE_LEN = 4,
  parameter int unsigned CAL_HALF  = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic [FIELD_W-1:0] sec_i,
  input  logic [FIELD_W-1:0] min_i,
  input  logic [FIELD_W-1:0] hour_i,
  input  logic [FIELD_W-1:0] date_i,
  input  logic               pfail_ev_i,
  input  logic               wdog_ev_i,
  input  logic               osc_fail_i,
  input  logic               reg_we_i,
  input  logic               reg_re_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [7:0]         reg_wdata_i,
  output logic [7:0]         reg_rdata_o,
  output logic               irq_o,
  output logic               cal_o
);
  logic [NFIELD-1:0][7:0]         alarm_q;
  logic [NFIELD-1:0][FIELD_W-1:0] now;
  logic [7:0] ictl_q, flags;
  logic       alarm_hit, flags_rd, flags_wr, active, trig;

  assign now = {date_i, hour_i, min_i, sec_i};

  for (genvar g = 0; g < NFIELD; g++) begin : g_alarm
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) alarm_q[g] <= '0;
      else if (reg_we_i && reg_addr_i == ADDR_W'(A_ASEC + g)) alarm_q[g] <= reg_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                ictl_q <= '0;
    else if (reg_we_i && reg_addr_i == A_ICTL)  ictl_q <= reg_wdata_i & IC_MASK;
  end

  alarm_match #(.NF(NFIELD), .FW(FIELD_W)) u_match (
    .alarm_i (alarm_q),
    .now_i   (now),
    .tick_i  (tick_i),
    .hit_o   (alarm_hit)
  );

  assign flags_rd = reg_re_i & (reg_addr_i == A_FLAGS);
  assign flags_wr = reg_we_i & (reg_addr_i == A_FLAGS);

  flag_reg u_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wdog_ev_i  (wdog_ev_i),
    .alarm_ev_i (alarm_hit),
    .pfail_ev_i (pfail_ev_i),
    .osc_ev_i   (osc_fail_i),
    .rd_i       (flags_rd),
    .wr_i       (flags_wr),
    .wdata_i    ({reg_wdata_i[FL_OSC], reg_wdata_i[FL_CAL], reg_wdata_i[FL_WEN], reg_wdata_i[FL_REN]}),
    .flags_o    (flags)
  );

  assign active = (flags[FL_WDOG]  & ictl_q[IC_WIE])
                | (flags[FL_ALARM] & ictl_q[IC_AIE])
                | (flags[FL_PFAIL] & ictl_q[IC_PFE]);
  assign trig   = (wdog_ev_i  & ictl_q[IC_WIE])
                | (alarm_hit  & ictl_q[IC_AIE])
                | (pfail_ev_i & ictl_q[IC_PFE]);

  irq_drive #(.PULSE_LEN(PULSE_LEN), .CAL_HALF(CAL_HALF)) u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (active),
    .trig_i   (trig),
    .level_i  (ictl_q[IC_LVL]),
    .pol_i    (ictl_q[IC_POL]),
    .cal_en_i (flags[FL_CAL]),
    .irq_o    (irq_o),
    .cal_o    (cal_o)
  );

  always_comb begin
    unique case (reg_addr_i)
      A_FLAGS: reg_rdata_o = flags;
      A_ICTL:  reg_rdata_o = ictl_q;
      A_ASEC:  reg_rdata_o = alarm_q[0];
      A_AMIN:  reg_rdata_o = alarm_q[1];
      A_AHR:   reg_rdata_o = alarm_q[2];
      A_ADATE: reg_rdata_o = alarm_q[3];
      default: reg_rdata_o = '0;
    endcase
  end

  // R3
  af_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags[FL_ALARM]) |-> $past(tick_i));
endmodule

// File: tb/tb_alarm_irq_unit.sv
module tb_alarm_irq_unit;
  localparam int PULSE_LEN = 4;
  localparam int CAL_HALF  = 32;

  logic       clk_i = 1'b0, rst_ni = 1'b0, tick_i = 1'b0;
  logic [6:0] sec_i = '0, min_i = '0, hour_i = '0, date_i = '0;
  logic       pfail_ev_i = 1'b0, wdog_ev_i = 1'b0, osc_fail_i = 1'b0;
  logic       reg_we_i = 1'b0, reg_re_i = 1'b0;
  logic [2:0] reg_addr_i = '0;
  logic [7:0] reg_wdata_i = '0, reg_rdata_o, rd;
  logic       irq_o, cal_o;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  alarm_irq_unit #(.PULSE_LEN(PULSE_LEN), .CAL_HALF(CAL_HALF)) dut (.*);

  // {a_sec, a_min, a_hr, a_date, t_sec, t_min, t_hr, t_date, expect_hit}
  localparam logic [64:0] VEC [9] = '{
    {8'h30, 8'h15, 8'h08, 8'h21, 8'h30, 8'h15, 8'h08, 8'h21, 1'b1},
    {8'h30, 8'h15, 8'h08, 8'h21, 8'h31, 8'h15, 8'h08, 8'h21, 1'b0},
    {8'hB0, 8'h15, 8'h08, 8'h21, 8'h45, 8'h15, 8'h08, 8'h21, 1'b1},
    {8'h80, 8'h80, 8'h80, 8'h80, 8'h12, 8'h34, 8'h05, 8'h17, 1'b1},
    {8'h30, 8'h15, 8'h09, 8'h21, 8'h30, 8'h15, 8'h08, 8'h21, 1'b0},
    {8'h30, 8'h15, 8'h88, 8'h21, 8'h30, 8'h15, 8'h23, 8'h21, 1'b1},
    {8'h80, 8'h80, 8'h80, 8'h12, 8'h00, 8'h00, 8'h00, 8'h13, 1'b0},
    {8'h80, 8'h80, 8'h80, 8'h12, 8'h59, 8'h59, 8'h23, 8'h12, 1'b1},
    {8'h80, 8'h59, 8'h80, 8'h80, 8'h00, 8'h49, 8'h00, 8'h00, 1'b0}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rdr(input logic [2:0] a, output logic [7:0] d);
    reg_re_i = 1'b1; reg_addr_i = a;
    #1 d = reg_rdata_o;
    @(negedge clk_i);
    reg_re_i = 1'b0;
  endtask

  task automatic pulse_pf();
    pfail_ev_i = 1'b1; @(negedge clk_i); pfail_ev_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL R1 watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rdr(3'(a), rd); chk("R1 reg reset", rd, 8'h00);
    end
    chk("R1 irq idle", {7'd0, irq_o}, 8'h01);
    chk("R1 cal idle", {7'd0, cal_o}, 8'h00);

    // R2 masked compare vectors
    foreach (VEC[i]) begin
      wr(3'd2, VEC[i][64:57]); wr(3'd3, VEC[i][56:49]);
      wr(3'd4, VEC[i][48:41]); wr(3'd5, VEC[i][40:33]);
      sec_i = VEC[i][31:25]; min_i = VEC[i][23:17];
      hour_i = VEC[i][15:9]; date_i = VEC[i][7:1];
      tick_i = 1'b1; @(negedge clk_i); tick_i = 1'b0;
      rdr(3'd0, rd); chk("R2 alarm vector", rd, VEC[i][0] ? 8'h40 : 8'h00);
    end
    rdr(3'd4, rd); chk("R11 alarm hours readback", rd, 8'h80);

    // R3 no tick, no flag (time still matches all-masked)
    wr(3'd2, 8'h80); wr(3'd3, 8'h80); wr(3'd4, 8'h80); wr(3'd5, 8'h80);
    repeat (5) @(negedge clk_i);
    rdr(3'd0, rd); chk("R3 no tick", rd, 8'h00);

    // R4 read clears, same-cycle event kept
    pulse_pf();
    rdr(3'd0, rd); chk("R4 pf set", rd, 8'h20);
    rdr(3'd0, rd); chk("R4 pf cleared by read", rd, 8'h00);
    pfail_ev_i = 1'b1; wdog_ev_i = 1'b1;
    rdr(3'd0, rd); pfail_ev_i = 1'b0; wdog_ev_i = 1'b0;
    chk("R4 read before event", rd, 8'h00);
    rdr(3'd0, rd); chk("R4 event kept across read", rd, 8'hA0);

    // R6 read-only bits
    wr(3'd0, 8'hE8);
    rdr(3'd0, rd); chk("R6 write ignored", rd, 8'h00);

    // R5 oscillator flag
    osc_fail_i = 1'b1; @(negedge clk_i); osc_fail_i = 1'b0;
    rdr(3'd0, rd); chk("R5 osc set", rd, 8'h10);
    rdr(3'd0, rd); chk("R5 osc survives read", rd, 8'h10);
    wr(3'd0, 8'h10);
    rdr(3'd0, rd); chk("R5 write 1 keeps", rd, 8'h10);
    wr(3'd0, 8'h03);
    rdr(3'd0, rd); chk("R11 plain bits / R5 cleared", rd, 8'h03);
    wr(3'd0, 8'h00);

    // R11 interrupt control masking, unused addresses
    wr(3'd1, 8'hFF);
    rdr(3'd1, rd); chk("R11 ictl mask", rd, 8'hEC);
    rdr(3'd6, rd); chk("R11 addr 6", rd, 8'h00);
    rdr(3'd7, rd); chk("R11 addr 7", rd, 8'h00);

    // R7 level mode, active high, pf enabled only
    wr(3'd1, 8'h2C);
    chk("R7 idle", {7'd0, irq_o}, 8'h00);
    wdog_ev_i = 1'b1; @(negedge clk_i); wdog_ev_i = 1'b0;
    chk("R7 disabled source", {7'd0, irq_o}, 8'h00);
    pulse_pf();
    chk("R7 asserted", {7'd0, irq_o}, 8'h01);
    repeat (6) @(negedge clk_i);
    chk("R7 held", {7'd0, irq_o}, 8'h01);
    rdr(3'd0, rd); chk("R7 flags", rd, 8'hA0);
    chk("R7 released by read", {7'd0, irq_o}, 8'h00);

    // R9 active low
    wr(3'd1, 8'h24);
    chk("R9 low idle", {7'd0, irq_o}, 8'h01);
    pulse_pf();
    chk("R9 low asserted", {7'd0, irq_o}, 8'h00);
    rdr(3'd0, rd);
    chk("R9 low released", {7'd0, irq_o}, 8'h01);

    // R8 pulse mode, active high
    wr(3'd1, 8'h28);
    pulse_pf();
    chk("R8 pulse start", {7'd0, irq_o}, 8'h01);
    for (int k = 1; k < PULSE_LEN; k++) begin
      @(negedge clk_i); chk("R8 pulse body", {7'd0, irq_o}, 8'h01);
    end
    @(negedge clk_i); chk("R8 pulse end", {7'd0, irq_o}, 8'h00);
    rdr(3'd0, rd); chk("R8 flag still set", rd, 8'h20);

    // R10 calibration wave
    wr(3'd0, 8'h04);
    for (int k = 1; k < CAL_HALF; k++) begin
      @(negedge clk_i); chk("R10 wave low", {6'd0, irq_o, cal_o}, 8'h00);
    end
    @(negedge clk_i); chk("R10 wave first rise", {6'd0, irq_o, cal_o}, 8'h03);
    repeat (CAL_HALF) @(negedge clk_i);
    chk("R10 wave fall", {6'd0, irq_o, cal_o}, 8'h00);
    wr(3'd0, 8'h00);
    repeat (CAL_HALF + 2) @(negedge clk_i);
    chk("R10 disabled", {7'd0, cal_o}, 8'h00);

    finish_run();
  end
endmodule